// File: doc/BRIEF.md
# Interrupt Flag/Enable and Core Identity Register Bank

This block is a small register bank on the synchronous peripheral bus of a 16-bit microcontroller. It holds an interrupt flag register and an interrupt enable register. Each has one bit for a watchdog source and one bit for a non-maskable interrupt source. Event pulses from those sources set the flags. Software reads, sets and clears both registers through the bus. Each flag ANDed with its enable drives an interrupt request output.

The bank also returns two kinds of fixed data. The first is a 32-bit core identity word, read as two 16-bit halves. It is packed from version fields and memory-size parameters that are scaled down by fixed shifts. The second is a core-number register that gives the instance index and the total core count. Parameters choose which interrupt sources exist. A bit for a source that is not present is always 0.

The bank decodes 16-bit word addresses. The read data is combinational and is zero for any address the bank does not own, so the bus can OR the read data of several peripherals together.

Top module: `periph_sfr_bank`

## Requirements
- R1: After reset, the flag register (offset 0) and the enable register (offset 1) read 0x0000, and `ifg_o`, `ie_o` and `irq_o` are all 0.
- R2: In both registers, bit 0 is the watchdog source (index 0 of `evt_i`/`ifg_o`/`ie_o`/`irq_o`) and bit 4 is the non-maskable source (index 1). Every other bit reads 0.
- R3: A source disabled by parameter reads 0 in both registers even after a 1 is written to its bit. Writing 0xFFFF reads back 0x0011 with both sources present, 0x0010 with the non-maskable source only, 0x0001 with the watchdog source only, and 0x0000 with neither.
- R4: A 1 on `evt_i` sets the flag on the next clock. The flag holds until software clears it. If an event and a software write of 0 land on the same clock, the flag is set.
- R5: A write of 0 to an implemented bit clears it on the next clock, provided no event arrives on that clock.
- R6: `wen_i[0]` writes the low byte of the addressed register and `wen_i[1]` writes the high byte. A high-byte-only write leaves both registers unchanged.
- R7: The identity word is {prog_mem>>10 (6 bits), data_mem>>7 (9 bits), multiplier flag, periph_space>>9 (7 bits), user version (5 bits), ASIC flag, core version (3 bits)`}` in that order from MSB to LSB. Its low half reads at offset 2 and its high half at offset 3.
- R8: Writes to offsets 2, 3 and 4 have no effect on what those offsets read.
- R9: Offset 4 reads {TOTAL_NR, INST_NR}; for example, 0x34 and 0x12 read as 0x3412.
- R10: `rdata_o` is 0x0000 for any address outside BASE_ADDR to BASE_ADDR+4, and writes to such addresses change no register.
- R11: `irq_o[s]` is 1 exactly when both `ifg_o[s]` and `ie_o[s]` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| wen_i | input | 2 | Byte write enables: [0] low byte, [1] high byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data; 0 when the address is not in the bank |
| evt_i | input | 2 | Event pulses: [0] watchdog, [1] non-maskable |
| ifg_o | output | 2 | Flag bits: [0] watchdog, [1] non-maskable |
| ie_o | output | 2 | Enable bits: [0] watchdog, [1] non-maskable |
| irq_o | output | 2 | Interrupt requests, flag AND enable |

## Verification
The assertions in the bit-register submodule assume one write strobe per register per clock and event pulses that are 1 for a single clock. Under those assumptions they relate each write or event to the bit's value on the next clock. The stimulus keeps to this by driving at most one bus access per cycle. The random phase pulses events on random sources, and some of those pulses land on the same clock as a write to the flag register, which exercises the case where the event wins. The random phase also mixes low-byte, high-byte, full and empty write enables across in-bank and out-of-bank addresses, so the byte-lane rule and the address decode are checked alongside the flag updates.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int NSRC       = 2;
  localparam int SRC_STRIDE = 4;  // watchdog at bit 0, nmi at bit 4

  localparam logic [2:0] OFS_IFG   = 3'd0;
  localparam logic [2:0] OFS_IE    = 3'd1;
  localparam logic [2:0] OFS_ID_LO = 3'd2;
  localparam logic [2:0] OFS_ID_HI = 3'd3;
  localparam logic [2:0] OFS_NUM   = 3'd4;

  function automatic logic [15:0] spread_bits(input logic [NSRC-1:0] q);
    logic [15:0] r;
    r = '0;
    for (int s = 0; s < NSRC; s++) r[s*SRC_STRIDE] = q[s];
    return r;
  endfunction
endpackage

// File: rtl/sfr_irq_bits.sv
module sfr_irq_bits
  import sfr_pkg::*;
#(
  parameter int              N      = NSRC,
  parameter logic [N-1:0]    SRC_EN = '1,
  parameter bit              IS_FLAG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [7:0]   wdata_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] q_o
);
  logic unused_ok;
  assign unused_ok = ^{evt_i, wdata_i};

  for (genvar s = 0; s < N; s++) begin : g_src
    localparam int B = s * SRC_STRIDE;
    if (SRC_EN[s]) begin : g_on
      logic q_r;
      logic set_w;
      assign set_w = IS_FLAG && evt_i[s];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q_r <= 1'b0;
        else if (set_w)  q_r <= 1'b1;  // event wins over clear
        else if (wr_i)   q_r <= wdata_i[B];
      end
      assign q_o[s] = q_r;

      if (IS_FLAG) begin : g_fa
        // R4
        evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          evt_i[s] |=> q_o[s]);
      end
      // R5
      wr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !wdata_i[B] && !(IS_FLAG && evt_i[s])) |=> !q_o[s]);
      // R2
      wr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && wdata_i[B]) |=> q_o[s]);
      // R6
      hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && !(IS_FLAG && evt_i[s])) |=> $stable(q_o[s]));
    end else begin : g_off
      assign q_o[s] = 1'b0;
    end
  end
endmodule

// File: rtl/sfr_id_pack.sv
module sfr_id_pack #(
  parameter logic [2:0] CPU_VER    = 3'd1,
  parameter bit         ASIC       = 1'b0,
  parameter logic [4:0] USER_VER   = 5'd0,
  parameter int         PER_BYTES  = 512,
  parameter bit         MPY_EN     = 1'b0,
  parameter int         DMEM_BYTES = 1024,
  parameter int         PMEM_BYTES = 4096
) (
  output logic [31:0] id_o
);
  localparam int PER_Q  = PER_BYTES  >> 9;
  localparam int DMEM_Q = DMEM_BYTES >> 7;
  localparam int PMEM_Q = PMEM_BYTES >> 10;
  localparam logic [6:0] PER_F  = PER_Q[6:0];
  localparam logic [8:0] DMEM_F = DMEM_Q[8:0];
  localparam logic [5:0] PMEM_F = PMEM_Q[5:0];

  assign id_o = {PMEM_F, DMEM_F, MPY_EN, PER_F, USER_VER, ASIC, CPU_VER};
endmodule

// File: rtl/periph_sfr_bank.sv
module periph_sfr_bank
  import sfr_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 8'h10,  // 8-word aligned
  parameter bit                WDT_EN     = 1'b1,
  parameter bit                NMI_EN     = 1'b1,
  parameter logic [2:0]        CPU_VER    = 3'd1,
  parameter bit                ASIC       = 1'b0,
  parameter logic [4:0]        USER_VER   = 5'd0,
  parameter int                PER_BYTES  = 512,
  parameter bit                MPY_EN     = 1'b0,
  parameter int                DMEM_BYTES = 1024,
  parameter int                PMEM_BYTES = 4096,
  parameter logic [7:0]        INST_NR    = 8'h00,
  parameter logic [7:0]        TOTAL_NR   = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        wen_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic [1:0]        evt_i,
  output logic [1:0]        ifg_o,
  output logic [1:0]        ie_o,
  output logic [1:0]        irq_o
);
  localparam logic [NSRC-1:0] SRC_EN = {NMI_EN, WDT_EN};

  logic        hit;
  logic [2:0]  ofs;
  logic        ifg_wr, ie_wr;
  logic [31:0] id_w;
  logic        unused_hi;

  assign ofs       = addr_i[2:0];
  assign hit       = (addr_i[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]) && (ofs <= OFS_NUM);
  assign ifg_wr    = hit && (ofs == OFS_IFG) && wen_i[0];
  assign ie_wr     = hit && (ofs == OFS_IE)  && wen_i[0];
  assign unused_hi = ^{wdata_i[15:8], wen_i[1]};  // no implemented bits in high byte

  sfr_irq_bits #(.N(NSRC), .SRC_EN(SRC_EN), .IS_FLAG(1'b1)) u_ifg (
    .clk_i, .rst_ni, .wr_i(ifg_wr), .wdata_i(wdata_i[7:0]), .evt_i, .q_o(ifg_o)
  );

  sfr_irq_bits #(.N(NSRC), .SRC_EN(SRC_EN), .IS_FLAG(1'b0)) u_ie (
    .clk_i, .rst_ni, .wr_i(ie_wr), .wdata_i(wdata_i[7:0]), .evt_i(2'b00), .q_o(ie_o)
  );

  sfr_id_pack #(
    .CPU_VER(CPU_VER), .ASIC(ASIC), .USER_VER(USER_VER), .PER_BYTES(PER_BYTES),
    .MPY_EN(MPY_EN), .DMEM_BYTES(DMEM_BYTES), .PMEM_BYTES(PMEM_BYTES)
  ) u_id (
    .id_o(id_w)
  );

  assign irq_o = ifg_o & ie_o;

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      case (ofs)
        OFS_IFG:   rdata_o = spread_bits(ifg_o);
        OFS_IE:    rdata_o = spread_bits(ie_o);
        OFS_ID_LO: rdata_o = id_w[15:0];
        OFS_ID_HI: rdata_o = id_w[31:16];
        OFS_NUM:   rdata_o = {TOTAL_NR, INST_NR};
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: tb/periph_sfr_bank_tb_top.sv
module periph_sfr_bank_tb_top;
  localparam logic [7:0] A_IFG = 8'h10, A_IE = 8'h11, A_LO = 8'h12, A_HI = 8'h13,
                         A_NUM = 8'h14, A_OUT = 8'h27, A_GAP = 8'h15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  wen = '0, evt = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_a, rd_b;
  logic [1:0]  ifg_a, ie_a, irq_a, ifg_b, ie_b, irq_b;
  logic [1:0]  m_ifg, m_ie;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  periph_sfr_bank #(
    .CPU_VER(3'd3), .ASIC(1'b0), .USER_VER(5'd7), .PER_BYTES(1024), .MPY_EN(1'b1),
    .DMEM_BYTES(2048), .PMEM_BYTES(8192), .INST_NR(8'h12), .TOTAL_NR(8'h34)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wen_i(wen), .wdata_i(wdata),
    .rdata_o(rd_a), .evt_i(evt), .ifg_o(ifg_a), .ie_o(ie_a), .irq_o(irq_a)
  );

  // watchdog source only
  periph_sfr_bank #(.NMI_EN(1'b0)) dut_w_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wen_i(wen), .wdata_i(wdata),
    .rdata_o(rd_b), .evt_i(evt), .ifg_o(ifg_b), .ie_o(ie_b), .irq_o(irq_b)
  );

  function automatic logic [15:0] to_reg(input logic [1:0] q);
    return {11'd0, q[1], 3'd0, q[0]};
  endfunction

  function automatic logic [31:0] exp_id();
    logic [5:0] pm; logic [8:0] dm; logic [6:0] ps;
    pm = 6'(8192 >> 10); dm = 9'(2048 >> 7); ps = 7'(1024 >> 9);
    return {pm, dm, 1'b1, ps, 5'd7, 1'b0, 3'd3};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] va, output logic [15:0] vb);
    addr = a; #1; va = rd_a; vb = rd_b;
  endtask

  // one bus cycle with optional events; model follows the requirements
  task automatic step(input logic [7:0] a, input logic [1:0] we, input logic [15:0] d,
                      input logic [1:0] e);
    @(negedge clk);
    addr = a; wen = we; wdata = d; evt = e;
    @(negedge clk);
    if (we[0] && a == A_IFG) m_ifg = {d[4], d[0]};
    if (we[0] && a == A_IE)  m_ie  = {d[4], d[0]};
    m_ifg = m_ifg | e;
    wen = '0; evt = '0;
  endtask

  task automatic chk_ports(input string req);
    chk({req, " ifg"},   {14'd0, ifg_a}, {14'd0, m_ifg});
    chk({req, " ie"},    {14'd0, ie_a},  {14'd0, m_ie});
    chk({req, " irq"},   {14'd0, irq_a}, {14'd0, m_ifg & m_ie});
    chk({req, " ifg_w"}, {14'd0, ifg_b}, {14'd0, m_ifg & 2'b01});
    chk({req, " irq_w"}, {14'd0, irq_b}, {14'd0, m_ifg & m_ie & 2'b01});
  endtask

  task automatic chk_regs(input string req);
    logic [15:0] a, b;
    rd(A_IFG, a, b);
    chk({req, " IFG"}, a, to_reg(m_ifg)); chk({req, " IFG_w"}, b, to_reg(m_ifg & 2'b01));
    rd(A_IE, a, b);
    chk({req, " IE"}, a, to_reg(m_ie));   chk({req, " IE_w"}, b, to_reg(m_ie & 2'b01));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    void'($urandom(32'd4711));
    m_ifg = '0; m_ie = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk_regs("R1"); chk_ports("R1");
    // R2 R3: all ones, then zero (R5)
    step(A_IFG, 2'b11, 16'hFFFF, 2'b00); chk_regs("R3 ifg ones");
    rd(A_IFG, a, b); chk("R3 both", a, 16'h0011); chk("R3 wdt only", b, 16'h0001);
    step(A_IE, 2'b11, 16'hFFFF, 2'b00); chk_regs("R3 ie ones");
    step(A_IFG, 2'b11, 16'h0000, 2'b00); chk_regs("R5 ifg clr");
    step(A_IE, 2'b11, 16'h0000, 2'b00); chk_regs("R5 ie clr");
    step(A_IFG, 2'b01, 16'h0010, 2'b00); chk_regs("R2 nmi bit4");
    chk("R2 ifg_o", {14'd0, ifg_a}, 16'h0002);
    step(A_IFG, 2'b01, 16'h0000, 2'b00);
    // R6 byte lanes
    step(A_IFG, 2'b10, 16'hFFFF, 2'b00); chk_regs("R6 hi only");
    chk("R6 hi only ifg", {14'd0, ifg_a}, 16'h0000);
    step(A_IFG, 2'b01, 16'h00FF, 2'b00); chk_regs("R6 lo");
    step(A_IFG, 2'b01, 16'h0000, 2'b00);
    // R4 events, and event wins over clear
    step(A_OUT, 2'b00, 16'h0000, 2'b11); chk_ports("R4 evt");
    chk("R4 set", {14'd0, ifg_a}, 16'h0003);
    step(A_NUM, 2'b00, 16'h0000, 2'b00); chk("R4 hold", {14'd0, ifg_a}, 16'h0003);
    step(A_IFG, 2'b01, 16'h0000, 2'b01); chk("R4 evt wins", {14'd0, ifg_a}, 16'h0001);
    chk_regs("R4 after");
    // R11
    step(A_IFG, 2'b01, 16'h0011, 2'b00);
    step(A_IE, 2'b01, 16'h0011, 2'b00);
    chk("R11 both", {14'd0, irq_a}, 16'h0003); chk_ports("R11");
    step(A_IE, 2'b01, 16'h0001, 2'b00);
    chk("R11 wdt", {14'd0, irq_a}, 16'h0001); chk_ports("R11 b");
    // R7 R9
    rd(A_LO, a, b); chk("R7 id lo", a, exp_id() >> 0 & 32'hFFFF);
    rd(A_HI, a, b); chk("R7 id hi", a, 16'(exp_id() >> 16));
    rd(A_NUM, a, b); chk("R9 num", a, 16'h3412);
    // R8
    step(A_LO, 2'b11, 16'hFFFF, 2'b00); step(A_HI, 2'b11, 16'h0000, 2'b00);
    step(A_NUM, 2'b11, 16'hA5A5, 2'b00);
    rd(A_LO, a, b); chk("R8 id lo", a, 16'(exp_id()));
    rd(A_HI, a, b); chk("R8 id hi", a, 16'(exp_id() >> 16));
    rd(A_NUM, a, b); chk("R8 num", a, 16'h3412);
    // R10
    rd(A_OUT, a, b); chk("R10 out", a, 16'h0000); chk("R10 out_w", b, 16'h0000);
    rd(A_GAP, a, b); chk("R10 gap", a, 16'h0000);
    step(A_OUT, 2'b11, 16'h0000, 2'b00); step(8'h18, 2'b11, 16'h0000, 2'b00);
    chk_regs("R10 no write");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ra;
      logic [1:0] re;
      int p;
      p  = $urandom % 4;
      ra = (p == 0) ? A_IFG : (p == 1) ? A_IE : (p == 2) ? A_IFG : 8'($urandom);
      re = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      step(ra, 2'($urandom), 16'($urandom), re);
      chk_ports("R4 R5 R6 R11 rnd");
      if (i % 8 == 0) chk_regs("R2 R3 rnd");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule